// File: doc/BRIEF.md
# Ring Generator Test Decompressor

This block expands a narrow stream of tester channel bits into one serial input bit per scan chain. A small ring shift register holds the decompressor state. Software-free seeding happens through a synchronous load strobe. After that, every accepted channel beat advances the ring by one step. In that step each ring cell takes its neighbour's value, the last cell's output is folded back into selected cells, and each channel bit is XORed into the cells picked for it. An XOR network then forms each scan-chain bit as the parity of a chosen subset of ring cells, so the block can feed more chains than the ring has cells.

Both data paths are streams. The channel input is accepted when `chan_valid` and `chan_ready` are both high at a clock edge, and every accepted beat is one shift cycle. The scan output beat is offered with `scan_valid` and is consumed when `scan_ready` is high at an edge. The block holds one output beat. It takes a new channel beat only when that slot is empty or is being drained in the same cycle, so a stalled consumer stops the ring without losing a beat. The output bits are the parity network applied to the current ring state, and they hold steady while a beat waits. After a full load of chain-length beats, every loaded scan cell is an XOR of seed bits and channel bits.

Top module: `ring_decompressor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the ring is cleared to all zeros and `scan_valid` goes low, so `scan_bits` reads all zeros afterwards.
- R2: A clock edge with `seed_load` high writes `seed` into the ring and empties the output slot, so afterwards `scan_valid` is low and `scan_bits` equals the parity network applied to the seed.
- R3: On each accepted channel beat, every ring cell i>0 takes the value of cell i-1, and cell 0 takes the value of the last cell. The last cell's output is also XORed into each cell whose bit is set in the feedback mask (default: cell 2).
- R4: On each accepted beat, channel bit c is XORed into the ring cells set in its injection mask (default: channel 0 into cell 1, channel 1 into cell 3).
- R5: Chain k's bit is the XOR of the ring cells set in its tap mask. The default masks are: chain 0 reads cell 1, chain 1 reads cell 2, chain 2 reads cells 0 and 3, and chain 3 reads cells 0 and 1.
- R6: Without an accepted channel beat and without a seed load, the ring does not change.
- R7: `chan_ready` is high exactly when `seed_load` is low and the output slot is empty or being drained. A waiting output beat keeps `scan_valid` high and `scan_bits` unchanged until it is consumed.
- R8: A seed load takes priority over the channel stream: `chan_ready` is low in that cycle and no beat is accepted.
- R9: When the bits of each chain are shifted serially into a chain of length L, the bit from the first accepted beat ends at position L-1, furthest from the input, and the last bit ends at position 0.
- R10: Each loaded chain cell equals the XOR of the value it gets from the seed with all channel bits zero and the value it gets from a zero seed with the same channel bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Strobe that writes `seed` into the ring |
| seed | input | RING_W | Seed value |
| chan_valid | input | 1 | Channel beat offered |
| chan_ready | output | 1 | Channel beat can be taken |
| chan_data | input | CHAN_W | Channel bits for one shift cycle |
| scan_valid | output | 1 | Scan output beat available |
| scan_ready | input | 1 | Consumer takes the scan beat |
| scan_bits | output | CHAINS | One bit per scan chain |

## Verification
`chan_ready` is combinational, so the bench samples it in the same cycle, after it drives the inputs at the falling edge. A seed load or an accepted channel beat changes the ring at the next rising edge. `scan_bits` is combinational from the ring, so its new value and the matching `scan_valid` are due one edge after the stimulus, and the bench checks them one time step after that edge. The bench records a scan beat as consumed in the cycle where it saw `scan_valid` and `scan_ready` high before the edge. After the full chain length has been consumed, it compares the contents of every modelled chain with a superposition it computes itself.

// File: rtl/rgd_pkg.sv
package rgd_pkg;
  localparam int DEF_RING_W = 4;
  localparam int DEF_CHAN_W = 2;
  localparam int DEF_CHAINS = 4;
  // feedback: last cell folds into cell 2 (bit 0 has no effect)
  localparam logic [DEF_RING_W-1:0] DEF_FB_TAPS = 4'b0100;
  // per channel RING_W-bit slice: ch0 -> cell 1, ch1 -> cell 3
  localparam logic [DEF_CHAN_W*DEF_RING_W-1:0] DEF_INJ_MASK = 8'h82;
  // per chain RING_W-bit slice: ch0=0x2, ch1=0x4, ch2=0x9, ch3=0x3
  localparam logic [DEF_CHAINS*DEF_RING_W-1:0] DEF_PS_TAPS = 16'h3942;
endpackage

// File: rtl/rgd_ring.sv
module rgd_ring #(
  parameter int RING_W = 4,
  parameter int CHAN_W = 2,
  parameter logic [RING_W-1:0] FB_TAPS = '0,
  parameter logic [CHAN_W*RING_W-1:0] INJ_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RING_W-1:0] seed,
  input  logic              step,
  input  logic [CHAN_W-1:0] chan,
  output logic [RING_W-1:0] state
);
  logic [RING_W-1:0] ring_q;
  logic [RING_W-1:0] ring_nxt;

  for (genvar i = 0; i < RING_W; i++) begin : g_cell
    localparam int PREV = (i + RING_W - 1) % RING_W;
    localparam bit FB_ON = (i > 0) && FB_TAPS[i];
    logic [CHAN_W-1:0] hit;
    logic fb;
    always_comb begin
      for (int c = 0; c < CHAN_W; c++) begin
        hit[c] = chan[c] & INJ_MASK[c*RING_W + i];
      end
    end
    if (FB_ON) begin : g_fb
      assign fb = ring_q[RING_W-1];
    end else begin : g_nofb
      assign fb = 1'b0;
    end
    assign ring_nxt[i] = ring_q[PREV] ^ fb ^ (^hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ring_q <= '0;
    else if (load) ring_q <= seed;
    else if (step) ring_q <= ring_nxt;
  end

  assign state = ring_q;

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state == $past(seed)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state));
endmodule

// File: rtl/rgd_phase_shifter.sv
module rgd_phase_shifter #(
  parameter int RING_W = 4,
  parameter int CHAINS = 4,
  parameter logic [CHAINS*RING_W-1:0] PS_TAPS = '0
) (
  input  logic [RING_W-1:0] state,
  output logic [CHAINS-1:0] bits
);
  for (genvar k = 0; k < CHAINS; k++) begin : g_chain
    localparam logic [RING_W-1:0] TAP = PS_TAPS[k*RING_W +: RING_W];
    assign bits[k] = ^(state & TAP);
  end
endmodule

// File: rtl/rgd_flow.sv
module rgd_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_load,
  input  logic chan_valid,
  output logic chan_ready,
  output logic scan_valid,
  input  logic scan_ready,
  output logic step
);
  logic full_q;

  assign chan_ready = !seed_load && (!full_q || scan_ready);
  assign step = chan_valid && chan_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) full_q <= 1'b0;
    else if (seed_load) full_q <= 1'b0;
    else if (step) full_q <= 1'b1;
    else if (scan_ready) full_q <= 1'b0;
  end

  assign scan_valid = full_q;

  assert_beat_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> scan_valid);
endmodule

// File: rtl/ring_decompressor.sv
module ring_decompressor #(
  parameter int RING_W = rgd_pkg::DEF_RING_W,
  parameter int CHAN_W = rgd_pkg::DEF_CHAN_W,
  parameter int CHAINS = rgd_pkg::DEF_CHAINS,
  parameter logic [RING_W-1:0] FB_TAPS = rgd_pkg::DEF_FB_TAPS,
  parameter logic [CHAN_W*RING_W-1:0] INJ_MASK = rgd_pkg::DEF_INJ_MASK,
  parameter logic [CHAINS*RING_W-1:0] PS_TAPS = rgd_pkg::DEF_PS_TAPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [RING_W-1:0] seed,
  input  logic              chan_valid,
  output logic              chan_ready,
  input  logic [CHAN_W-1:0] chan_data,
  output logic              scan_valid,
  input  logic              scan_ready,
  output logic [CHAINS-1:0] scan_bits
);
  logic              step;
  logic [RING_W-1:0] ring_state;

  rgd_flow u_flow (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .chan_valid (chan_valid),
    .chan_ready (chan_ready),
    .scan_valid (scan_valid),
    .scan_ready (scan_ready),
    .step       (step)
  );

  rgd_ring #(
    .RING_W   (RING_W),
    .CHAN_W   (CHAN_W),
    .FB_TAPS  (FB_TAPS),
    .INJ_MASK (INJ_MASK)
  ) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_load),
    .seed  (seed),
    .step  (step),
    .chan  (chan_data),
    .state (ring_state)
  );

  rgd_phase_shifter #(
    .RING_W  (RING_W),
    .CHAINS  (CHAINS),
    .PS_TAPS (PS_TAPS)
  ) u_ps (
    .state (ring_state),
    .bits  (scan_bits)
  );

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && !scan_ready && !seed_load) |=> (scan_valid && $stable(scan_bits)));
endmodule

// File: tb/ring_decompressor_tb.sv
module ring_decompressor_tb;
  localparam int W = 4;
  localparam int CW = 2;
  localparam int NCH = 4;
  localparam int LEN = 3;
  localparam logic [W-1:0] FB = 4'b0100;
  localparam logic [CW*W-1:0] INJ = 8'h82;
  localparam logic [NCH*W-1:0] PS = 16'h3942;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_load = 1'b0;
  logic [W-1:0] seed = '0;
  logic chan_valid = 1'b0;
  logic chan_ready;
  logic [CW-1:0] chan_data = '0;
  logic scan_valid;
  logic scan_ready = 1'b0;
  logic [NCH-1:0] scan_bits;

  int n_tests = 0;
  int n_fail = 0;

  logic [W-1:0] m_ring;
  logic m_valid;

  always #5 clk = ~clk;

  ring_decompressor u_dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
    .chan_valid(chan_valid), .chan_ready(chan_ready), .chan_data(chan_data),
    .scan_valid(scan_valid), .scan_ready(scan_ready), .scan_bits(scan_bits)
  );

  function automatic logic [W-1:0] f_next(input logic [W-1:0] s, input logic [CW-1:0] c);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      n[i] = s[(i + W - 1) % W];
      if (i > 0 && FB[i]) n[i] = n[i] ^ s[W-1];
      for (int j = 0; j < CW; j++) if (INJ[j*W + i]) n[i] = n[i] ^ c[j];
    end
    return n;
  endfunction

  function automatic logic [NCH-1:0] f_ps(input logic [W-1:0] s);
    logic [NCH-1:0] b;
    for (int k = 0; k < NCH; k++) begin
      b[k] = 1'b0;
      for (int i = 0; i < W; i++) if (PS[k*W + i]) b[k] = b[k] ^ s[i];
    end
    return b;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    check(scan_valid == m_valid, {tag, " R7 valid"}, 32'(scan_valid), 32'(m_valid));
    check(scan_bits == f_ps(m_ring), {tag, " R5 bits"}, 32'(scan_bits), 32'(f_ps(m_ring)));
  endtask

  task automatic do_load(input logic [W-1:0] s);
    @(negedge clk);
    seed_load = 1'b1; seed = s;
    chan_valid = 1'($urandom % 2); chan_data = CW'($urandom); scan_ready = 1'($urandom % 2);
    #1;
    check(chan_ready == 1'b0, "R8 ready low on load", 32'(chan_ready), 32'h0);
    @(posedge clk);
    m_ring = s; m_valid = 1'b0;
    @(negedge clk);
    seed_load = 1'b0; chan_valid = 1'b0; scan_ready = 1'b0;
    check(scan_valid == 1'b0, "R2 valid cleared", 32'(scan_valid), 32'h0);
    check(scan_bits == f_ps(s), "R2 seed visible", 32'(scan_bits), 32'(f_ps(s)));
  endtask

  task automatic run_pattern(input logic [W-1:0] s);
    logic [LEN-1:0] chains [NCH];
    logic [CW-1:0] used [LEN];
    int injected;
    int collected;
    logic fire_in;
    logic fire_out;
    logic [W-1:0] sa;
    logic [W-1:0] sb;
    logic [NCH-1:0] oa;
    logic [NCH-1:0] ob;
    logic [NCH-1:0] exp_b;
    for (int k = 0; k < NCH; k++) chains[k] = '0;
    for (int t = 0; t < LEN; t++) used[t] = '0;
    do_load(s);
    injected = 0; collected = 0;
    while (collected < LEN) begin
      @(negedge clk);
      chan_valid = (injected < LEN) && ($urandom % 4 != 0);
      chan_data = CW'($urandom);
      scan_ready = ($urandom % 3 != 0);
      #1;
      check(chan_ready == (!m_valid || scan_ready), "R7 ready", 32'(chan_ready), 32'(!m_valid || scan_ready));
      check_out("stream");
      fire_in = chan_valid && chan_ready;
      fire_out = scan_valid && scan_ready;
      if (fire_out) begin
        for (int k = 0; k < NCH; k++) chains[k] = {chains[k][LEN-2:0], scan_bits[k]};
        collected++;
      end
      if (fire_in) used[injected] = chan_data;
      @(posedge clk);
      if (fire_in) begin
        m_ring = f_next(m_ring, chan_data);
        m_valid = 1'b1;
        injected++;
      end else if (scan_ready) m_valid = 1'b0;
    end
    @(negedge clk);
    chan_valid = 1'b0; scan_ready = 1'b0;
    sa = s; sb = '0;
    for (int t = 0; t < LEN; t++) begin
      sa = f_next(sa, '0); sb = f_next(sb, used[t]);
      oa = f_ps(sa); ob = f_ps(sb);
      exp_b = oa ^ ob;
      for (int k = 0; k < NCH; k++)
        check(chains[k][LEN-1-t] == exp_b[k], (t == 0) ? "R9 first bit deepest" : "R10 superposition",
              32'(chains[k][LEN-1-t]), 32'(exp_b[k]));
    end
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0D1E));
    m_ring = '0; m_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(scan_valid == 1'b0, "R1 valid after reset", 32'(scan_valid), 32'h0);
    check(scan_bits == '0, "R1 bits after reset", 32'(scan_bits), 32'h0);
    rst_n = 1'b1;

    // R4: injection from a zero ring, channel 0 lands in cell 1
    do_load('0);
    chan_valid = 1'b1; chan_data = 2'b01; scan_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chan_valid = 1'b0;
    check(scan_bits == 4'b1001, "R4 chan0 to cell1", 32'(scan_bits), 32'h9);
    // R6: idle with a waiting beat, ring and bits hold
    scan_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(scan_valid == 1'b1, "R7 beat held", 32'(scan_valid), 32'h1);
    check(scan_bits == 4'b1001, "R6 no change when idle", 32'(scan_bits), 32'h9);
    // R8: load while channel offered wins
    do_load('0);
    chan_valid = 1'b1; chan_data = 2'b10; scan_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chan_valid = 1'b0;
    check(scan_bits == 4'b0100, "R4 chan1 to cell3", 32'(scan_bits), 32'h4);
    // R3: feedback, last cell set, no channel bits
    do_load(4'b1000);
    chan_valid = 1'b1; chan_data = 2'b00; scan_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chan_valid = 1'b0;
    m_ring = 4'b0101; m_valid = 1'b1;
    check(scan_bits == f_ps(4'b0101), "R3 rotate and feedback", 32'(scan_bits), 32'(f_ps(4'b0101)));

    for (int p = 0; p < 60; p++) run_pattern(W'($urandom));

    // R1: reset in mid-run clears a nonzero ring
    do_load(4'b1111);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(scan_bits == '0, "R1 mid-run reset", 32'(scan_bits), 32'h0);
    check(scan_valid == 1'b0, "R1 valid mid-run reset", 32'(scan_valid), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule